// File: doc/BRIEF.md
# I2S IQ Ping-Pong Capture Buffer

This block receives a stereo audio-codec stream in I2S format and turns it into in-phase and quadrature sample words for a radio signal path. The left channel is the in-phase (I) stream and the right channel is the quadrature (Q) stream. Each channel carries a 24-bit two's-complement sample. The bit clock, word select and serial data pins are asynchronous to the system clock. They are synchronised and oversampled inside the block. The bit clock must therefore run well below a quarter of the system clock, which a codec at 16 to 100 kS/s easily allows.

Each completed I/Q pair is sign-extended to 32 bits. It leaves the block as two words on a valid/ready write stream that feeds an external memory: I goes to an even word address and Q to the odd address just above it. The memory is split into two banks of `PAIRS` pairs. While the block writes one bank, a reader works on the other. When the last word of a bank is accepted, the block raises a ready flag, reports the index of the completed bank and goes on writing into the other bank. The reader hands a bank back with a one-cycle release pulse. If a bank completes while the reader still holds the other bank, an overrun flag is set and the bank swap still takes place.

Back-pressure rules: a word stays on the stream, with address and data unchanged, until `wr_ready` is high in a clock cycle with `wr_valid` high. The I2S side cannot be stalled. The sink must accept both words of a pair before the next pair completes, which takes one I2S frame. A pair that completes while the previous pair is still held is discarded, and the address does not advance.

Top module: `iq_pingpong_capture`

## Requirements
- R1: After reset, `wr_valid`, `buf_rdy` and `buf_ovr` are low.
- R2: A channel word starts at the second bit-clock rising edge after a word-select change. The first 24 bits are taken MSB first, and any further bits in the slot are ignored. A word received while word select is low (0) is I, and one received while it is high (1) is Q.
- R3: Each 24-bit sample is written as a 32-bit word whose bits 31:24 all equal sample bit 23.
- R4: The write address is {bank bit, pair index, lane bit}. I uses lane 0 and is written before Q, which uses lane 1. Each following pair uses the next pair index. After the last pair of bank 1 the address wraps to bank 0, pair 0.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R6: A pair that completes while the previous pair is not yet fully accepted is dropped without advancing the address. The next accepted pair takes the address the dropped pair would have used.
- R7: A Q word with no I word before it in the same frame is dropped and produces no write.
- R8: The cycle after the last word of a bank (lane 1, highest pair index) is accepted, `buf_rdy` is high and `buf_idx` is that bank's bit.
- R9: A `buf_rel` pulse, in a cycle where no bank completes, clears `buf_rdy` and `buf_ovr` the next cycle.
- R10: If a bank completes while the other bank is still ready and not released, `buf_ovr` rises the next cycle. `buf_idx` moves to the newly completed bank, and `buf_ovr` stays set until a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2s_sck | input | 1 | I2S bit clock (asynchronous) |
| i2s_ws | input | 1 | I2S word select: 0 = I (left), 1 = Q (right) |
| i2s_sd | input | 1 | I2S serial data, MSB first |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Sink accepts the word this cycle |
| wr_addr | output | log2(PAIRS)+2 | Word address {bank, pair index, lane} |
| wr_data | output | WORD_W | Sign-extended sample |
| buf_rdy | output | 1 | A completed bank awaits the reader |
| buf_idx | output | 1 | Index of the most recently completed bank |
| buf_rel | input | 1 | One-cycle pulse: reader hands the bank back |
| buf_ovr | output | 1 | A bank completed while the other was still held |

## Verification
The assertions check on every cycle that:
- address and data stay stable under back-pressure;
- the upper bits of each word carry the sample's sign;
- a Q word always follows its I word at the next address;
- the ready flag and bank index follow a bank's last accepted word;
- a release clears the flags;
- an unreleased bank turns into an overrun.

Only the bench scenarios can show that the serial bits are taken from the right edges and slot positions, that tail bits after bit 24 are ignored, and that a lone Q word and a pair arriving during a stall are dropped without a gap in the addresses.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;

  // Channel tag carried with each deserialised word; value equals word select.
  typedef enum logic {
    CH_I = 1'b0,
    CH_Q = 1'b1
  } chan_e;

  // Default widths shared by the capture modules.
  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_WORD_W   = 32;

endpackage

// File: rtl/iqcap_i2s_deser.sv
module iqcap_i2s_deser
  import iqcap_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                ws,
  input  logic                sd,
  output logic                word_v,
  output chan_e               word_ch,
  output logic [SAMPLE_W-1:0] word_data
);

  localparam int CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  // The bit clock has one extra stage for edge detection. Word select and
  // data are delayed by the same depth, so all three line up.
  logic [SYNC_STAGES:0]   sck_q;
  logic [SYNC_STAGES-1:0] ws_q;
  logic [SYNC_STAGES-1:0] sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], sck};
      ws_q  <= {ws_q[SYNC_STAGES-2:0], ws};
      sd_q  <= {sd_q[SYNC_STAGES-2:0], sd};
    end
  end

  logic sck_rise, ws_b, sd_b;
  assign sck_rise = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
  assign ws_b     = ws_q[SYNC_STAGES-1];
  assign sd_b     = sd_q[SYNC_STAGES-1];

  logic                started;
  logic                ws_prev;
  logic                active;
  logic [CNT_W-1:0]    cnt;
  chan_e               chan;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg[SAMPLE_W-2:0], sd_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started   <= 1'b0;
      ws_prev   <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
      chan      <= CH_I;
      shreg     <= '0;
      word_v    <= 1'b0;
      word_ch   <= CH_I;
      word_data <= '0;
    end else begin
      word_v <= 1'b0;
      if (sck_rise) begin
        started <= 1'b1;
        ws_prev <= ws_b;
        if (started && (ws_b != ws_prev)) begin
          // This edge still carries the previous word's last bit; the MSB comes next.
          active <= 1'b1;
          cnt    <= '0;
          chan   <= ws_b ? CH_Q : CH_I;
        end else if (active) begin
          shreg <= shreg_nxt;
          if (cnt == LAST_BIT) begin
            active    <= 1'b0;
            word_v    <= 1'b1;
            word_ch   <= chan;
            word_data <= shreg_nxt;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/iqcap_pair_stage.sv
module iqcap_pair_stage
  import iqcap_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int WORD_W   = DEF_WORD_W,
  parameter int PAIRS    = 1024,
  localparam int IDX_W   = $clog2(PAIRS),
  localparam int PTR_W   = IDX_W + 1,
  localparam int ADDR_W  = PTR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_v,
  input  chan_e               word_ch,
  input  logic [SAMPLE_W-1:0] word_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data
);

  localparam int EXT_W = WORD_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] i_hold;
  logic                i_have;
  logic [WORD_W-1:0]   i_ext, q_ext;

  // Sign extension into the memory word width.
  generate
    if (EXT_W > 0) begin : g_ext
      assign i_ext = {{EXT_W{i_hold[SAMPLE_W-1]}}, i_hold};
      assign q_ext = {{EXT_W{word_data[SAMPLE_W-1]}}, word_data};
    end else begin : g_trunc
      assign i_ext = i_hold[WORD_W-1:0];
      assign q_ext = word_data[WORD_W-1:0];
    end
  endgenerate

  logic pair_v;
  assign pair_v = word_v & (word_ch == CH_Q) & i_have;

  logic [WORD_W-1:0] h_i, h_q;
  logic [PTR_W-1:0]  h_ptr;
  logic              h_v;
  logic              h_lane;
  logic [PTR_W-1:0]  ptr;

  logic accept, handshake;
  assign accept    = pair_v & ~h_v;
  assign handshake = h_v & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_hold <= '0;
      i_have <= 1'b0;
    end else if (word_v) begin
      if (word_ch == CH_I) begin
        i_hold <= word_data;
        i_have <= 1'b1;
      end else begin
        i_have <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_i    <= '0;
      h_q    <= '0;
      h_ptr  <= '0;
      h_v    <= 1'b0;
      h_lane <= 1'b0;
      ptr    <= '0;
    end else begin
      if (handshake) begin
        if (h_lane) begin
          h_v    <= 1'b0;
          h_lane <= 1'b0;
        end else begin
          h_lane <= 1'b1;
        end
      end
      if (accept) begin
        h_v    <= 1'b1;
        h_lane <= 1'b0;
        h_i    <= i_ext;
        h_q    <= q_ext;
        h_ptr  <= ptr;
        ptr    <= ptr + 1'b1;
      end
    end
  end

  assign wr_valid = h_v;
  assign wr_addr  = {h_ptr, h_lane};
  assign wr_data  = h_lane ? h_q : h_i;

endmodule

// File: rtl/iqcap_bank_ctrl.sv
module iqcap_bank_ctrl #(
  parameter int PAIRS   = 1024,
  localparam int IDX_W  = $clog2(PAIRS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rel,
  output logic              rdy,
  output logic              idx,
  output logic              ovr
);

  logic       bank_end;
  logic       bank;
  logic [1:0] pend;
  logic [1:0] pend_n;
  logic       ovr_n;

  assign bank     = wr_addr[ADDR_W-1];
  assign bank_end = wr_fire & wr_addr[0] & (&wr_addr[ADDR_W-2:1]);

  always_comb begin
    pend_n = rel ? 2'b00 : pend;
    ovr_n  = rel ? 1'b0  : ovr;
    if (bank_end) begin
      if (pend_n[~bank]) ovr_n = 1'b1;
      pend_n       = 2'b00;
      pend_n[bank] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'b00;
      ovr  <= 1'b0;
      idx  <= 1'b0;
    end else begin
      pend <= pend_n;
      ovr  <= ovr_n;
      if (bank_end) idx <= bank;
    end
  end

  assign rdy = |pend;

endmodule

// File: rtl/iq_pingpong_capture.sv
module iq_pingpong_capture
  import iqcap_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int WORD_W      = DEF_WORD_W,
  parameter int PAIRS       = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(PAIRS) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i2s_sck,
  input  logic              i2s_ws,
  input  logic              i2s_sd,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              buf_rdy,
  output logic              buf_idx,
  input  logic              buf_rel,
  output logic              buf_ovr
);

  logic                word_v;
  chan_e               word_ch;
  logic [SAMPLE_W-1:0] word_data;

  iqcap_i2s_deser #(
    .SAMPLE_W   (SAMPLE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (i2s_sck),
    .ws       (i2s_ws),
    .sd       (i2s_sd),
    .word_v   (word_v),
    .word_ch  (word_ch),
    .word_data(word_data)
  );

  iqcap_pair_stage #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W),
    .PAIRS   (PAIRS)
  ) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_v   (word_v),
    .word_ch  (word_ch),
    .word_data(word_data),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  iqcap_bank_ctrl #(
    .PAIRS(PAIRS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_fire(wr_valid & wr_ready),
    .wr_addr(wr_addr),
    .rel    (buf_rel),
    .rdy    (buf_rdy),
    .idx    (buf_idx),
    .ovr    (buf_ovr)
  );

endmodule

// File: rtl/iq_pingpong_capture_sva.sv
module iq_pingpong_capture_sva #(
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              buf_rdy,
  input logic              buf_idx,
  input logic              buf_rel,
  input logic              buf_ovr
);

  logic last_word;
  assign last_word = wr_valid & wr_ready & wr_addr[0] & (&wr_addr[ADDR_W-2:1]);

  // R5: a stalled word keeps its address and data
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R3: upper bits replicate the sample sign
  p_sign_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[WORD_W-1:SAMPLE_W-1] == {(WORD_W-SAMPLE_W+1){wr_data[SAMPLE_W-1]}}));

  // R4: an accepted I word is followed at once by its Q word at the next address
  p_lane_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_addr[0]) |=> (wr_valid && wr_addr == $past(wr_addr) + 1'b1));

  // R8: the last word of a bank raises the ready flag with that bank's index
  p_bank_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (buf_rdy && buf_idx == $past(wr_addr[ADDR_W-1])));

  // R9: a release with no completion clears both flags
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rel && !last_word) |=> (!buf_rdy && !buf_ovr));

  // R10: a completion while the other bank is still held sets the overrun flag
  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_word && !buf_rel && buf_rdy && (buf_idx != wr_addr[ADDR_W-1])) |=> buf_ovr);

  // R10: the overrun flag holds until a release
  p_overrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ovr && !buf_rel) |=> buf_ovr);

endmodule

bind iq_pingpong_capture iq_pingpong_capture_sva #(
  .SAMPLE_W(SAMPLE_W),
  .WORD_W  (WORD_W),
  .ADDR_W  (ADDR_W)
) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .buf_rdy (buf_rdy),
  .buf_idx (buf_idx),
  .buf_rel (buf_rel),
  .buf_ovr (buf_ovr)
);

// File: tb/iq_pingpong_capture_test.sv
`timescale 1ns/1ps
module iq_pingpong_capture_test;

  localparam int PAIRS  = 4;
  localparam int ADDR_W = $clog2(PAIRS) + 2;
  localparam int IDX_W  = $clog2(PAIRS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic wr_valid, wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic buf_rdy, buf_idx, buf_ovr;
  logic buf_rel = 1'b0;

  always #10 clk = ~clk;

  iq_pingpong_capture #(.PAIRS(PAIRS)) uut (
    .clk(clk), .rst_n(rst_n),
    .i2s_sck(sck), .i2s_ws(ws), .i2s_sd(sd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_rdy(buf_rdy), .buf_idx(buf_idx), .buf_rel(buf_rel), .buf_ovr(buf_ovr)
  );

  // Sink model: word memory and accepted-word count.
  logic [31:0] mem [2**ADDR_W];
  int wcount = 0;
  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      wcount <= wcount + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  int g = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] vi(int k);
    return 24'((k + 3) * 32'h2F6A39 ^ 32'h5A5A5A);
  endfunction
  function automatic logic [23:0] vq(int k);
    return 24'((k + 7) * 32'h1B3C5D ^ 32'h00C3A5);
  endfunction
  function automatic logic [31:0] sext(logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  // One bit-clock period of 8 system clocks; ws and sd change while sck is low.
  task automatic bit_slot(input logic w, input logic d);
    sck = 1'b0; ws = w; sd = d;
    #80;
    sck = 1'b1;
    #80;
  endtask

  // 32-bit channel slot: slot 0 carries the old word's tail bit, slots 1..24 the sample.
  task automatic send_ch(input logic w, input logic [23:0] v, input logic tail);
    logic b;
    for (int j = 0; j < 32; j++) begin
      if (j >= 1 && j <= 24) b = v[24-j];
      else b = tail;
      bit_slot(w, b);
    end
  endtask

  task automatic send_frame(input logic [23:0] iv, input logic [23:0] qv, input logic tail);
    send_ch(1'b0, iv, tail);
    send_ch(1'b1, qv, tail);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_release();
    @(negedge clk) buf_rel = 1'b1;
    @(negedge clk) buf_rel = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 wr_valid", 32'(wr_valid), 32'd0);
    chk("R1 buf_rdy", 32'(buf_rdy), 32'd0);
    chk("R1 buf_ovr", 32'(buf_ovr), 32'd0);
  endtask

  task automatic t_lone_q();
    int c0;
    c0 = wcount;
    bit_slot(1'b0, 1'b0);            // first edge only arms the receiver
    send_ch(1'b1, 24'h5A5A5A, 1'b1); // Q with no I before it
    settle();
    chk("R7 lone Q writes", 32'(wcount - c0), 32'd0);
    chk("R7 wr_valid", 32'(wr_valid), 32'd0);
  endtask

  task automatic t_fill_bank(input logic bank, input logic exp_ovr);
    int base, c0;
    base = g;
    c0 = wcount;
    for (int k = 0; k < PAIRS; k++) begin
      send_frame(vi(g), vq(g), 1'(k));
      g++;
    end
    settle();
    chk("R4 word count", 32'(wcount - c0), 32'(2 * PAIRS));
    for (int k = 0; k < PAIRS; k++) begin
      logic [ADDR_W-1:0] a;
      a = {bank, IDX_W'(k), 1'b0};
      chk("R2 R3 R4 I word", mem[a], sext(vi(base + k)));
      chk("R2 R3 R4 Q word", mem[a + 1'b1], sext(vq(base + k)));
    end
    chk("R8 buf_rdy", 32'(buf_rdy), 32'd1);
    chk("R8 buf_idx", 32'(buf_idx), 32'(bank));
    chk("R10 buf_ovr", 32'(buf_ovr), 32'(exp_ovr));
  endtask

  task automatic t_release();
    pulse_release();
    chk("R9 buf_rdy after release", 32'(buf_rdy), 32'd0);
    chk("R9 buf_ovr after release", 32'(buf_ovr), 32'd0);
  endtask

  task automatic t_backpressure();
    logic [23:0] ai, aq, bi, bq, ci, cq;
    int c0;
    ai = 24'h800123; aq = 24'h7FFFFE;
    bi = 24'h111111; bq = 24'h222222;
    ci = 24'hFEDCBA; cq = 24'h013579;
    @(negedge clk) wr_ready = 1'b0;
    c0 = wcount;
    send_frame(ai, aq, 1'b1);
    settle();
    chk("R5 wr_valid held", 32'(wr_valid), 32'd1);
    chk("R5 wr_addr held", 32'(wr_addr), 32'd8);
    chk("R5 wr_data held", wr_data, sext(ai));
    send_frame(bi, bq, 1'b0);        // completes during the stall
    settle();
    chk("R6 stall keeps addr", 32'(wr_addr), 32'd8);
    chk("R6 stall keeps data", wr_data, sext(ai));
    @(negedge clk) wr_ready = 1'b1;
    settle();
    chk("R6 words after stall", 32'(wcount - c0), 32'd2);
    chk("R6 stalled I", mem[8], sext(ai));
    chk("R6 stalled Q", mem[9], sext(aq));
    send_frame(ci, cq, 1'b1);
    settle();
    chk("R6 next I no gap", mem[10], sext(ci));
    chk("R6 next Q no gap", mem[11], sext(cq));
    chk("R6 total words", 32'(wcount - c0), 32'd4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lone_q();
    t_fill_bank(1'b0, 1'b0);
    t_release();
    t_fill_bank(1'b1, 1'b0);
    t_fill_bank(1'b0, 1'b1);  // bank 1 never released: overrun
    t_release();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule